// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 32 interrupt request lines into two interrupt outputs, a normal one and a fast one. Each output has its own register bank, and the two banks share one layout. In each bank, software sets for every line whether the line is enabled, whether it is sensed by level or by edge, and which polarity counts as active. It then reads which enabled lines are pending. Edge events are held in a latch until software acknowledges them by writing a one to the line's clear bit. A level-sensed line is pending for exactly as long as its synchronised input stays active.

Every input passes through a two-flop synchroniser before any sensing, so the block can take asynchronous request lines. Software reaches the registers through a 32-bit port with single-cycle access. A write takes effect at the clock edge on which the write strobe is high, and read data reflects the current register state in the same cycle. A service routine reads a bank's status register, handles the lowest-numbered set bit, acknowledges it, and reads the status again until it is zero. The block does no priority encoding and no vectoring.

Register offsets, on byte addresses with the low two bits zero. The fast bank is the normal bank plus 0x20:
- 0x00 / 0x20: synchronised input lines (read-only)
- 0x04 / 0x24: enable, where 1 enables the line
- 0x08 / 0x28: acknowledge; a written 1 clears the line's edge latch, and the register reads 0
- 0x0C / 0x2C: sensing, where 0 is level and 1 is edge
- 0x10 / 0x30: polarity
- 0x14 / 0x34: pending AND enable (read-only)

Bit i of every register belongs to line i. Address decode works as follows. Bit 5 selects the bank, bits 4:2 select the register, and any other address is unmapped.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, the enable, sensing and polarity registers of both banks read 0, every edge latch is clear, both status registers read 0, and both interrupt outputs are 0.
- R2: Bit i of the source register (0x00 and 0x20) shows input line i after two clock edges of synchronisation.
- R3: With sensing bit 0, a line is pending while its synchronised input XOR its polarity bit is 1. Polarity 0 therefore means active high, and polarity 1 means active low.
- R4: With sensing bit 1, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The latch stays set after the input returns, and the opposite edge does not set it.
- R5: Writing a 1 to bit i of the acknowledge register clears line i's edge latch in that bank. Writing a 0 leaves the latch unchanged. The acknowledge register reads 0.
- R6: If a new qualifying edge and an acknowledge of the same line fall on the same clock edge, the latch ends up set.
- R7: The status register equals the pending lines AND the enable register. Clearing an enable bit hides a latched edge without losing it, and setting the bit again shows the edge.
- R8: Each interrupt output is the OR of its bank's status bits, registered once. It changes one clock edge after the status changes.
- R9: The two banks are independent. Writes to one bank's enable, sensing, polarity or acknowledge registers do not change the other bank's registers, status or output.
- R10: Reads from an unmapped address return 0, and writes to an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Interrupt request lines, may be asynchronous |
| bus_we_i | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, same cycle |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_fast_o | output | 1 | Fast interrupt output |

## Verification
An input change applied at a falling clock edge shows in the source register and in level status after two rising edges. An edge latch and its status bit update after three rising edges, and the registered output follows one edge after the status. A register write takes effect at the rising edge that ends the write cycle. The bench applies every stimulus at a falling edge, waits exactly these counts of falling edges, and then samples the outputs a nanosecond later. The same-edge case for an acknowledge and a new edge comes from placing the acknowledge write on the third rising edge after the input moves.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register index inside a bank, taken from address bits 4:2.
    typedef enum logic [2:0] {
        REG_SRC  = 3'd0,
        REG_EN   = 3'd1,
        REG_ACK  = 3'd2,
        REG_SENS = 3'd3,
        REG_POL  = 3'd4,
        REG_STAT = 3'd5
    } bank_reg_e;

    localparam int unsigned NUM_BANKS  = 2;
    localparam int unsigned BANK_BIT   = 5;
    localparam int unsigned LAST_INDEX = 5;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [STAGES-1:0][N-1:0] stage_q;
    logic [N-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign level_o = stage_q[STAGES-1];
    assign rise_o  = stage_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         we_i,
    input  bank_reg_e    reg_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    output logic [N-1:0] rdata_o,
    output logic         irq_o
);

    logic [N-1:0] en_q, sens_q, pol_q, latch_q;
    logic [N-1:0] edge_hit, ack_vec, level_act, pending, status;
    logic         wr;

    assign wr = hit_i & we_i;

    // Write decode: acknowledge is a one-cycle pulse vector.
    always_comb begin
        ack_vec = '0;
        if (wr && reg_i == REG_ACK) ack_vec = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            sens_q <= '0;
            pol_q  <= '0;
        end else if (wr) begin
            unique case (reg_i)
                REG_EN:   en_q   <= wdata_i;
                REG_SENS: sens_q <= wdata_i;
                REG_POL:  pol_q  <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Edge qualification per line: polarity 1 rising, 0 falling.
    assign edge_hit = sens_q & ((pol_q & rise_i) | (~pol_q & fall_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~ack_vec) | edge_hit;
    end

    assign level_act = level_i ^ pol_q;
    assign pending   = (sens_q & latch_q) | (~sens_q & level_act);
    assign status    = pending & en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |status;
    end

    always_comb begin
        rdata_o = '0;
        if (hit_i) begin
            unique case (reg_i)
                REG_SRC:  rdata_o = level_i;
                REG_EN:   rdata_o = en_q;
                REG_ACK:  rdata_o = '0;
                REG_SENS: rdata_o = sens_q;
                REG_POL:  rdata_o = pol_q;
                REG_STAT: rdata_o = status;
                default:  rdata_o = '0;
            endcase
        end
    end

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_vec & ~edge_hit) != '0) |=> ((latch_q & $past(ack_vec & ~edge_hit)) == '0));

    // R8
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|status)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (en_q == '0 && sens_q == '0 && pol_q == '0 && latch_q == '0 && !irq_o));

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic                 irq_norm_o,
    output logic                 irq_fast_o
);

    localparam int unsigned HI_LSB = BANK_BIT + 1;

    logic [NUM_LINES-1:0] lvl, rise, fall;
    logic [NUM_LINES-1:0] bank_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;
    logic                 addr_ok;
    bank_reg_e            reg_sel;

    intc_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_lines_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        reg_sel = bank_reg_e'(bus_addr_i[4:2]);
        addr_ok = (bus_addr_i[1:0] == 2'b00)
               && (bus_addr_i[ADDR_W-1:HI_LSB] == '0)
               && (int'(bus_addr_i[4:2]) <= int'(LAST_INDEX));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = addr_ok && (bus_addr_i[BANK_BIT] == b[0]);
        intc_bank #(.N(NUM_LINES)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit),
            .we_i    (bus_we_i),
            .reg_i   (reg_sel),
            .wdata_i (bus_wdata_i),
            .level_i (lvl),
            .rise_i  (rise),
            .fall_i  (fall),
            .rdata_o (bank_rdata[b]),
            .irq_o   (bank_irq[b])
        );
    end

    assign bus_rdata_o = bank_rdata[0] | bank_rdata[1];
    assign irq_norm_o  = bank_irq[0];
    assign irq_fast_o  = bank_irq[1];

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |-> (bus_rdata_o == '0));

endmodule

// File: tb/tb_intc_dual_bank.sv
module tb_intc_dual_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    intc_dual_bank dut (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_norm_o(irq_norm), .irq_fast_o(irq_fast)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks enter and leave just after a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_all();
        logic [31:0] pol_pat;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1);
        for (int r = 0; r < 6; r++) begin
            rd("R1", 8'(r * 4), 32'h0);
            rd("R1", 8'(8'h20 + r * 4), 32'h0);
        end
        #1 chk("R1", {30'h0, irq_norm, irq_fast}, 32'h0);

        // R2 source register after two edges
        lines = 32'hA5C3_0F91;
        cyc(1);
        rd("R2", 8'h00, 32'h0);
        cyc(1);
        rd("R2", 8'h00, 32'hA5C3_0F91);
        rd("R2", 8'h20, 32'hA5C3_0F91);
        lines = '0;
        cyc(3);

        // R3 level sweep on the normal bank, active high
        wr(8'h04, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            lines = 32'h1 << i;
            cyc(2);
            rd("R3", 8'h14, 32'h1 << i);
            #1 chk("R8 norm before", {31'h0, irq_norm}, 32'h0);
            cyc(1);
            #1 chk("R8 norm", {31'h0, irq_norm}, 32'h1);
            chk("R9 fast idle", {31'h0, irq_fast}, 32'h0);
            lines = '0;
            cyc(3);
        end
        // R3 polarity 1 is active low
        wr(8'h10, 32'hFFFF_0000);
        rd("R3 active low", 8'h14, 32'hFFFF_0000);
        wr(8'h10, 32'h0);
        rd("R3 restore", 8'h14, 32'h0);
        wr(8'h04, 32'h0);
        rd("R7 mask off", 8'h04, 32'h0);

        // R4 edge sweep on the fast bank: even lines rising, odd falling
        pol_pat = 32'h5555_5555;
        lines = ~pol_pat;
        cyc(4);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h30, pol_pat);
        rd("R9 norm sens", 8'h0C, 32'h0);
        rd("R9 norm pol", 8'h10, 32'h0);
        rd("R4 idle", 8'h34, 32'h0);
        for (int i = 0; i < 32; i++) begin
            lines[i] = ~lines[i];
            cyc(3);
            rd("R4 edge", 8'h34, 32'h1 << i);
            cyc(1);
            #1 chk("R8 fast", {31'h0, irq_fast}, 32'h1);
            lines[i] = ~lines[i];
            cyc(3);
            rd("R4 held", 8'h34, 32'h1 << i);
            wr(8'h28, 32'h1 << i);
            rd("R5 ack", 8'h34, 32'h0);
            cyc(1);
            #1 chk("R8 fast clear", {31'h0, irq_fast}, 32'h0);
        end
        #1 chk("R9 norm idle", {31'h0, irq_norm}, 32'h0);

        // R7 masking hides and restores a latched edge on line 3 (falling)
        lines[3] = 1'b0;
        cyc(3);
        wr(8'h24, 32'h0);
        rd("R7 hidden", 8'h34, 32'h0);
        cyc(1);
        #1 chk("R7 irq hidden", {31'h0, irq_fast}, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
        rd("R7 shown", 8'h34, 32'h8);
        wr(8'h28, 32'h0);
        rd("R5 zero write", 8'h34, 32'h8);
        rd("R5 ack reads 0", 8'h28, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd("R9 other ack", 8'h34, 32'h8);
        wr(8'h28, 32'h8);
        rd("R5 ack 3", 8'h34, 32'h0);
        lines[3] = 1'b1;
        cyc(3);

        // R6 edge and acknowledge on the same rising edge (line 5, falling)
        lines[5] = 1'b0;
        cyc(2);
        wr(8'h28, 32'h20);
        rd("R6 edge wins", 8'h34, 32'h20);
        wr(8'h28, 32'h20);
        rd("R6 later ack", 8'h34, 32'h0);

        // R10 unmapped addresses
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h26, 32'h0);
        rd("R10 read 18", 8'h18, 32'h0);
        rd("R10 read 44", 8'h44, 32'h0);
        rd("R10 norm en", 8'h04, 32'h0);
        rd("R10 fast en", 8'h24, 32'hFFFF_FFFF);
        rd("R10 norm sens", 8'h0C, 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule